// File: doc/BRIEF.md
# ADC Conversion Trigger Selector

This block decides when an analog-to-digital converter starts a conversion. It emits a one-cycle request strobe, `conv_req`. A 3-bit source field picks where the start comes from: an external start pin, the output of an on-chip programmable logic element, or a software write strobe. A mode bit makes the two hardware sources edge-triggered or level-triggered. The two sources use opposite polarities. The pin fires on a falling edge, or on a high level. The logic element fires on a rising edge, or on a low level.

Both hardware inputs are asynchronous to the system clock. Each is registered on the system clock before any detection is done, so a short pulse is seen reliably when it spans at least one clock edge. The block tracks one conversion in flight, from its request until the converter pulses `conv_done`. An edge or software start that arrives during that window is discarded and sets a sticky overrun flag. Software clears the flag by writing 1. A held level is not an overrun. It simply starts the next conversion once the current one is done.

Top module: `adc_trig_sel`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `conv_req` and `ovr_flag` are 0.
- R2: With `cfg_src` = 3'b000 and `cfg_edge_mode` = 1, each falling edge on `ext_start_pin` gives exactly one `conv_req` pulse. A rising edge gives none. If the pin is first sampled low at clock edge k, `conv_req` is high for the one cycle after edge k+1.
- R3: With `cfg_src` = 3'b000 and `cfg_edge_mode` = 0, a high level on the pin requests a conversion. While the level stays high, another request follows in the cycle after each `conv_done`.
- R4: With `cfg_src` = 3'b101 and `cfg_edge_mode` = 1, each rising edge on `logic_trig_in` gives exactly one pulse. A falling edge gives none.
- R5: With `cfg_src` = 3'b101 and `cfg_edge_mode` = 0, a low level on `logic_trig_in` requests a conversion. The request repeats after each `conv_done` while the level stays low.
- R6: With any other `cfg_src` code, each cycle of `sw_start_wr` = 1 gives one pulse, and both hardware inputs are ignored. Under codes 000 and 101, `sw_start_wr` has no effect.
- R7: No `conv_req` is issued between a request and the next `conv_done`, and two requests never appear in adjacent cycles.
- R8: An edge or software start that arrives while a conversion is in flight produces no request and sets `ovr_flag`. A level held during a conversion never sets it.
- R9: `ovr_flag` stays set until a cycle with `ovr_clr_wr` = 1 clears it. If a new overrun arrives in the same cycle as the clear, the flag stays set.
- R10: Changing `cfg_src` or `cfg_edge_mode` while the hardware inputs are steady at their inactive levels produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_edge_mode | input | 1 | 1 = edge trigger, 0 = level trigger |
| cfg_src | input | 3 | Source code: 000 pin, 101 logic element, others software |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| logic_trig_in | input | 1 | Asynchronous programmable logic output |
| sw_start_wr | input | 1 | Software start write strobe |
| conv_done | input | 1 | Converter end-of-conversion pulse |
| ovr_clr_wr | input | 1 | Write-1 clear of the overrun flag |
| conv_req | output | 1 | One-cycle conversion start strobe |
| ovr_flag | output | 1 | Sticky trigger-overrun flag |

## Verification
The bench checks that each source uses its own polarity in both modes. A design that swaps polarity fires on the wrong edge, or fires continuously in the idle state. It sends edges and software writes while a conversion is in flight. A design without in-flight tracking would issue a second request there, and one that ignores overruns would leave the flag clear. It holds levels across several `conv_done` pulses to catch a request that is not repeated, or that is repeated before `done`. Other targets are a clear in the same cycle as a new overrun, and source changes on idle inputs, where a shared or badly reset sampler would emit a false edge.

// File: rtl/adc_trig_pkg.sv
// Package: source codes and routing type shared by the trigger selector.
package adc_trig_pkg;

    localparam int SRC_W = 3;
    localparam logic [SRC_W-1:0] SRC_CODE_PIN   = 3'b000;
    localparam logic [SRC_W-1:0] SRC_CODE_LOGIC = 3'b101;

    // Number of asynchronous hardware trigger inputs (pin, logic element).
    localparam int N_HW = 2;
    localparam int HW_PIN   = 0;
    localparam int HW_LOGIC = 1;

    typedef enum logic [1:0] {
        ROUTE_PIN,
        ROUTE_LOGIC,
        ROUTE_SOFT
    } trig_route_e;

    // Maps the raw source field onto a route; unlisted codes fall to software.
    function automatic trig_route_e decode_src(input logic [SRC_W-1:0] code);
        if (code == SRC_CODE_PIN)        return ROUTE_PIN;
        else if (code == SRC_CODE_LOGIC) return ROUTE_LOGIC;
        else                             return ROUTE_SOFT;
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
// Module: adc_trig_sync
// Registers one asynchronous input on the system clock through STAGES flops
// and keeps one further delayed copy for edge detection.
// Assumes: the input pulse spans at least one clock edge; RST_VAL is the
// inactive level of the input so that reset release creates no edge.
module adc_trig_sync #(
    parameter int   STAGES  = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic smp,
    output logic smp_d
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw input into the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {CHAIN_W{RST_VAL}};
        else        chain <= {chain[CHAIN_W-2:0], async_in};
    end

    assign smp   = chain[STAGES-1];
    assign smp_d = chain[STAGES];

endmodule

// File: rtl/adc_trig_detect.sv
// Module: adc_trig_detect
// Turns a registered sample pair into a level hit and an edge hit.
// The active edge is the transition that leaves the active level, so one
// polarity parameter fixes both the level and the edge sense of a source.
// Assumes: smp_d is smp delayed by exactly one clock.
module adc_trig_detect #(
    parameter logic ACT_HIGH = 1'b1
) (
    input  logic smp,
    input  logic smp_d,
    output logic level_hit,
    output logic edge_hit
);

    // Level and edge qualification for one source.
    always_comb begin
        level_hit = (smp == ACT_HIGH);
        edge_hit  = (smp_d == ACT_HIGH) && (smp != ACT_HIGH);
    end

endmodule

// File: rtl/adc_trig_ctrl.sv
// Module: adc_trig_ctrl
// Chooses the trigger source, gates requests against the conversion in
// flight, drives the one-cycle request and keeps the sticky overrun flag.
// Assumes: conv_done pulses once per requested conversion.
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int NHW = N_HW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_edge_mode,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [NHW-1:0]   hw_edge,
    input  logic [NHW-1:0]   hw_level,
    input  logic             sw_start_wr,
    input  logic             conv_done,
    input  logic             ovr_clr_wr,
    output logic             conv_req,
    output logic             ovr_flag
);

    trig_route_e route;
    logic        evt;       // discrete event: edge or software write
    logic        lvl;       // persistent level request
    logic        inflight;
    logic        fire;

    // Select the event and level request of the chosen source.
    always_comb begin
        route = decode_src(cfg_src);
        evt   = 1'b0;
        lvl   = 1'b0;
        unique case (route)
            ROUTE_PIN: begin
                evt = cfg_edge_mode  & hw_edge[HW_PIN];
                lvl = ~cfg_edge_mode & hw_level[HW_PIN];
            end
            ROUTE_LOGIC: begin
                evt = cfg_edge_mode  & hw_edge[HW_LOGIC];
                lvl = ~cfg_edge_mode & hw_level[HW_LOGIC];
            end
            default: evt = sw_start_wr;
        endcase
        fire = (evt | lvl) & ~inflight;
    end

    // Register the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_req <= 1'b0;
        else        conv_req <= fire;
    end

    // Track the one conversion in flight from request to done.
    always_ff @(posedge clk) begin
        if (!rst_n)         inflight <= 1'b0;
        else if (fire)      inflight <= 1'b1;
        else if (conv_done) inflight <= 1'b0;
    end

    // Sticky overrun: a new overrun wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovr_flag <= 1'b0;
        else if (evt && inflight) ovr_flag <= 1'b1;
        else if (ovr_clr_wr)      ovr_flag <= 1'b0;
    end

endmodule

// File: rtl/adc_trig_sel.sv
// Module: adc_trig_sel (top)
// ADC conversion trigger selector. Registers each hardware trigger on the
// system clock, qualifies it by edge or level with its own polarity, and
// hands the result to the controller that issues conversion requests.
// Assumes: hardware inputs are asynchronous; cfg_* come from a register file.
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_edge_mode,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic             ext_start_pin,
    input  logic             logic_trig_in,
    input  logic             sw_start_wr,
    input  logic             conv_done,
    input  logic             ovr_clr_wr,
    output logic             conv_req,
    output logic             ovr_flag
);

    // Per-source active level: pin active high, logic element active low.
    localparam logic [N_HW-1:0] ACT_HIGH_V = 2'b01;

    logic [N_HW-1:0] hw_raw;
    logic [N_HW-1:0] hw_smp;
    logic [N_HW-1:0] hw_smp_d;
    logic [N_HW-1:0] hw_edge;
    logic [N_HW-1:0] hw_level;

    assign hw_raw[HW_PIN]   = ext_start_pin;
    assign hw_raw[HW_LOGIC] = logic_trig_in;

    for (genvar gi = 0; gi < N_HW; gi++) begin : g_hw
        adc_trig_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (~ACT_HIGH_V[gi])
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (hw_raw[gi]),
            .smp      (hw_smp[gi]),
            .smp_d    (hw_smp_d[gi])
        );

        adc_trig_detect #(
            .ACT_HIGH (ACT_HIGH_V[gi])
        ) u_det (
            .smp       (hw_smp[gi]),
            .smp_d     (hw_smp_d[gi]),
            .level_hit (hw_level[gi]),
            .edge_hit  (hw_edge[gi])
        );
    end

    adc_trig_ctrl #(
        .NHW (N_HW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_edge_mode (cfg_edge_mode),
        .cfg_src       (cfg_src),
        .hw_edge       (hw_edge),
        .hw_level      (hw_level),
        .sw_start_wr   (sw_start_wr),
        .conv_done     (conv_done),
        .ovr_clr_wr    (ovr_clr_wr),
        .conv_req      (conv_req),
        .ovr_flag      (ovr_flag)
    );

endmodule

// File: rtl/adc_trig_sel_chk.sv
// Module: adc_trig_sel_chk
// Port-level properties of the trigger selector, bound to every instance.
module adc_trig_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_src,
    input logic       sw_start_wr,
    input logic       conv_done,
    input logic       ovr_clr_wr,
    input logic       conv_req,
    input logic       ovr_flag
);

    logic chk_busy;

    // Independent view of a conversion in flight, from the strobe until done.
    always_ff @(posedge clk) begin
        if (!rst_n)         chk_busy <= 1'b0;
        else if (conv_done) chk_busy <= 1'b0;
        else if (conv_req)  chk_busy <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!conv_req && !ovr_flag));

    p_no_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    p_no_req_in_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> !chk_busy);

    p_soft_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && $past(cfg_src) != 3'b000 && $past(cfg_src) != 3'b101)
            |-> $past(sw_start_wr));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr_wr) |=> ovr_flag);

endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_src     (cfg_src),
    .sw_start_wr (sw_start_wr),
    .conv_done   (conv_done),
    .ovr_clr_wr  (ovr_clr_wr),
    .conv_req    (conv_req),
    .ovr_flag    (ovr_flag)
);

// File: tb/adc_trig_sel_tb.sv
// Bench for adc_trig_sel: behavioural reference model compared every clock,
// plus directed pulse counts per scenario.
module adc_trig_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_edge_mode = 1'b1;
    logic [2:0] cfg_src = 3'b000;
    logic       ext_start_pin = 1'b0;
    logic       logic_trig_in = 1'b1;
    logic       sw_start_wr = 1'b0;
    logic       conv_done = 1'b0;
    logic       ovr_clr_wr = 1'b0;
    logic       conv_req;
    logic       ovr_flag;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 0;

    // Reference model state.
    bit m_pin_q[$];
    bit m_lg_q[$];
    bit m_req, m_busy, m_ovr;

    always #2 clk = ~clk;

    adc_trig_sel dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_edge_mode (cfg_edge_mode),
        .cfg_src       (cfg_src),
        .ext_start_pin (ext_start_pin),
        .logic_trig_in (logic_trig_in),
        .sw_start_wr   (sw_start_wr),
        .conv_done     (conv_done),
        .ovr_clr_wr    (ovr_clr_wr),
        .conv_req      (conv_req),
        .ovr_flag      (ovr_flag)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock of the reference model; queues hold [newest, older] samples.
    task automatic model_step();
        bit p_new, p_old, l_new, l_old, ev, lv, fire;
        if (!rst_n) begin
            m_pin_q = '{0, 0};
            m_lg_q  = '{1, 1};
            m_req = 0; m_busy = 0; m_ovr = 0;
            return;
        end
        p_new = m_pin_q[0]; p_old = m_pin_q[1];
        l_new = m_lg_q[0];  l_old = m_lg_q[1];
        ev = 0; lv = 0;
        if (cfg_src == 3'b000) begin
            if (cfg_edge_mode) ev = p_old && !p_new;
            else               lv = p_new;
        end else if (cfg_src == 3'b101) begin
            if (cfg_edge_mode) ev = !l_old && l_new;
            else               lv = !l_new;
        end else begin
            ev = sw_start_wr;
        end
        fire = (ev || lv) && !m_busy;
        if (ev && m_busy)    m_ovr = 1;
        else if (ovr_clr_wr) m_ovr = 0;
        if (fire)           m_busy = 1;
        else if (conv_done) m_busy = 0;
        m_req = fire;
        m_pin_q.push_front(ext_start_pin); void'(m_pin_q.pop_back());
        m_lg_q.push_front(logic_trig_in);  void'(m_lg_q.pop_back());
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        #1;
        model_step();
        check(conv_req == m_req, tag, "conv_req", conv_req, m_req);
        check(ovr_flag == m_ovr, tag, "ovr_flag", ovr_flag, m_ovr);
        if (conv_req) pulses++;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic done_pulse(input string tag);
        conv_done = 1; tick(tag); conv_done = 0;
    endtask

    task automatic expect_pulses(input int exp, input string tag);
        check(pulses == exp, tag, "pulse count", pulses, exp);
        pulses = 0;
    endtask

    initial begin
        run(3, "R1");
        check(conv_req == 0 && ovr_flag == 0, "R1", "reset outputs", conv_req, 0);
        rst_n = 1;
        tick("R1");
        check(conv_req == 0, "R1", "first cycle after reset", conv_req, 0);
        ext_start_pin = 1;
        run(4, "R2"); pulses = 0;

        // R2: falling edge on the pin, exact latency.
        ext_start_pin = 0;
        tick("R2");
        check(conv_req == 0, "R2", "no request one edge after sampling", conv_req, 0);
        tick("R2");
        check(conv_req == 1, "R2", "request after second edge", conv_req, 1);
        run(4, "R2");
        ext_start_pin = 1; run(4, "R2");
        expect_pulses(1, "R2");
        done_pulse("R2");
        ext_start_pin = 0; run(3, "R2");
        ext_start_pin = 1; run(3, "R2");
        expect_pulses(1, "R2");

        // R8/R7: second falling edge while in flight is dropped, sets overrun.
        ext_start_pin = 0; run(3, "R8");
        ext_start_pin = 1; run(3, "R8");
        expect_pulses(0, "R7");
        check(ovr_flag == 1, "R8", "overrun set", ovr_flag, 1);
        run(3, "R9");
        check(ovr_flag == 1, "R9", "overrun sticky", ovr_flag, 1);
        ovr_clr_wr = 1; tick("R9"); ovr_clr_wr = 0;
        check(ovr_flag == 0, "R9", "overrun cleared", ovr_flag, 0);
        done_pulse("R7");
        pulses = 0;

        // R3: pin level mode, repeats after done while high.
        ext_start_pin = 0; run(3, "R3");
        cfg_edge_mode = 0; run(2, "R3");
        ext_start_pin = 1; run(5, "R3");
        expect_pulses(1, "R3");
        done_pulse("R3");
        tick("R3");
        expect_pulses(1, "R3");
        run(4, "R8");
        check(ovr_flag == 0, "R8", "held level no overrun", ovr_flag, 0);
        ext_start_pin = 0; done_pulse("R3"); run(4, "R3");
        expect_pulses(0, "R3");

        // R10: switch sources and modes with inputs idle.
        cfg_src = 3'b101; run(3, "R10");
        cfg_edge_mode = 1; run(3, "R10");
        cfg_src = 3'b010; run(3, "R10");
        cfg_src = 3'b000; run(3, "R10");
        expect_pulses(0, "R10");

        // R4: logic element rising edge.
        cfg_src = 3'b101;
        logic_trig_in = 0; run(4, "R4");
        expect_pulses(0, "R4");
        logic_trig_in = 1; run(4, "R4");
        expect_pulses(1, "R4");
        done_pulse("R4"); run(2, "R4");
        expect_pulses(0, "R4");

        // R5: logic element low level, repeats after done.
        cfg_edge_mode = 0;
        logic_trig_in = 0; run(4, "R5");
        done_pulse("R5"); run(3, "R5");
        expect_pulses(2, "R5");
        logic_trig_in = 1; done_pulse("R5"); run(3, "R5");
        expect_pulses(0, "R5");

        // R6: software start, hardware inputs ignored.
        cfg_src = 3'b011; cfg_edge_mode = 1;
        sw_start_wr = 1; tick("R6"); sw_start_wr = 0;
        run(2, "R6");
        expect_pulses(1, "R6");
        done_pulse("R6");
        ext_start_pin = 1; run(2, "R6"); ext_start_pin = 0;
        logic_trig_in = 0; run(2, "R6"); logic_trig_in = 1;
        run(3, "R6");
        expect_pulses(0, "R6");
        cfg_src = 3'b000; run(2, "R6");
        sw_start_wr = 1; tick("R6"); sw_start_wr = 0; run(3, "R6");
        expect_pulses(0, "R6");

        // R9: new overrun in the same cycle as a clear keeps the flag.
        cfg_src = 3'b111;
        sw_start_wr = 1; tick("R9"); sw_start_wr = 0; run(2, "R9");
        sw_start_wr = 1; tick("R9"); sw_start_wr = 0;
        check(ovr_flag == 1, "R8", "soft overrun", ovr_flag, 1);
        sw_start_wr = 1; ovr_clr_wr = 1; tick("R9");
        sw_start_wr = 0; ovr_clr_wr = 0;
        check(ovr_flag == 1, "R9", "set wins over clear", ovr_flag, 1);
        done_pulse("R9"); run(2, "R9");
        expect_pulses(1, "R7");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule